// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which DMA channel is serviced next. Every cycle it looks at a vector of channel requests and produces a registered grant that names one channel. A run-time mode input selects between two policies. In fixed-priority mode each channel carries a programmable priority value. Channels are split into a lower and an upper group, and a configuration bit names the group that is searched first. In round-robin mode the priority values play no part. A pointer walks the channels in descending index order, wrapping from channel 0 back to the top channel.

The grant leaves the block on a valid/ready stream. A grant is taken when `gnt_valid_o` and `gnt_ready_i` are both high on a rising edge. While `gnt_valid_o` is high and `gnt_ready_i` is low, the offered channel is held. New requests are not looked at until that grant is taken. Whenever the output register is empty or being emptied, the block samples the current requests and loads a new grant one cycle later. The round-robin pointer moves only when a grant made in round-robin mode is taken.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset `gnt_valid_o` is 0 and the round-robin pointer points at the top channel (NUM_CH-1). The first round-robin grant with every channel requesting is therefore channel NUM_CH-1.
- R2: When the output register is empty or its grant is taken on an edge, and at least one request bit is set at that edge, `gnt_valid_o` is 1 after that edge.
- R3: When the output register is empty or its grant is taken, and no request bit is set, `gnt_valid_o` is 0 after the edge.
- R4: While `gnt_valid_o` is 1 and `gnt_ready_i` is 0, `gnt_valid_o` stays 1 and `gnt_chan_o` stays unchanged, whatever the requests do.
- R5: In fixed-priority mode (`rr_mode_i` = 0), the granted channel is the requester with the numerically largest priority within the group searched. Channel c's priority is `prio_i[c*PRIO_W +: PRIO_W]`.
- R6: In fixed-priority mode, when requesters in the searched group tie on priority, the higher channel index is granted.
- R7: In fixed-priority mode, the lower group is channels 0..NUM_CH/2-1 and the upper group is the rest. `grp_first_i` = 0 searches the lower group first and `grp_first_i` = 1 searches the upper group first. The other group is granted only when the first group has no request, whatever the priority values are.
- R8: In round-robin mode (`rr_mode_i` = 1), priorities are ignored. The grant is the first requester found scanning downward from the pointer, with the scan wrapping from channel 0 to NUM_CH-1.
- R9: When a grant made in round-robin mode is taken, the pointer becomes that channel minus one (modulo NUM_CH), and this new value already applies to the grant loaded on the same edge. The pointer holds in every other cycle, including idle cycles and cycles with fixed-priority grants.
- R10: A newly loaded grant always names a channel whose request bit was set on the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel service requests |
| prio_i | input | NUM_CH*PRIO_W | Packed per-channel priority values, larger is stronger |
| rr_mode_i | input | 1 | 0 selects fixed priority, 1 selects round robin |
| grp_first_i | input | 1 | Group searched first in fixed-priority mode: 0 lower, 1 upper |
| gnt_valid_o | output | 1 | A grant is offered |
| gnt_ready_i | input | 1 | The consumer takes the offered grant |
| gnt_chan_o | output | $clog2(NUM_CH) | Index of the granted channel |

## Verification
The bench uses the defaults: 32 channels in two groups of 16, with 4-bit priorities. At this size the bench can place ties, and it can set a priority of 15 in the group searched second to show that the group order wins over the priority value. Thirty-two channels also let the round-robin scan pass from channel 0 back to channel 31 in a few cycles. With these settings, back-pressure, idle cycles and mode changes can be mixed in a single short run. The run shows that the pointer advances only when a round-robin grant is taken.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_RR    = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_arb_grp_max.sv
// Finds the strongest requester inside one group; ties go to the higher index.
module dma_arb_grp_max #(
  parameter int GRP_SIZE = 16,
  parameter int PRIO_W   = 4,
  localparam int GW      = $clog2(GRP_SIZE)
) (
  input  logic [GRP_SIZE-1:0]        req_i,
  input  logic [GRP_SIZE*PRIO_W-1:0] prio_i,
  output logic                       hit_o,
  output logic [GW-1:0]              idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < GRP_SIZE; i++) begin
      // ascending scan with >= lets a later (higher) index win a tie
      if (req_i[i] && (!hit_o || prio_i[i*PRIO_W +: PRIO_W] >= best)) begin
        hit_o = 1'b1;
        idx_o = GW'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dma_arb_fixed.sv
// Fixed-priority selection across two channel groups.
module dma_arb_fixed #(
  parameter int NUM_CH  = 32,
  parameter int PRIO_W  = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int GRP_SZ = NUM_CH / 2,
  localparam int GW     = CH_W - 1
) (
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     grp_first_i,
  output logic                     hit_o,
  output logic [CH_W-1:0]          chan_o
);
  logic [1:0]    ghit;
  logic [GW-1:0] gidx [2];
  logic          sel;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    dma_arb_grp_max #(
      .GRP_SIZE (GRP_SZ),
      .PRIO_W   (PRIO_W)
    ) u_max (
      .req_i  (req_i[g*GRP_SZ +: GRP_SZ]),
      .prio_i (prio_i[g*GRP_SZ*PRIO_W +: GRP_SZ*PRIO_W]),
      .hit_o  (ghit[g]),
      .idx_o  (gidx[g])
    );
  end

  always_comb begin
    sel = grp_first_i;
    if (!ghit[sel]) sel = ~grp_first_i;
    hit_o  = |ghit;
    chan_o = {sel, gidx[sel]};
  end
endmodule

// File: rtl/dma_arb_rr.sv
// Descending scan from a start index, wrapping below zero to the top channel.
module dma_arb_rr #(
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [CH_W-1:0]   start_i,
  output logic              hit_o,
  output logic [CH_W-1:0]   chan_o
);
  logic [CH_W-1:0] cand;

  always_comb begin
    hit_o  = 1'b0;
    chan_o = '0;
    cand   = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      cand = start_i - CH_W'(k);
      if (!hit_o && req_i[cand]) begin
        hit_o  = 1'b1;
        chan_o = cand;
      end
    end
  end
endmodule

// File: rtl/dma_arb_out.sv
// Grant register with valid/ready hold and the round-robin pointer.
module dma_arb_out #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cand_hit_i,
  input  logic [CH_W-1:0] cand_chan_i,
  input  logic            cand_rr_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [CH_W-1:0] chan_o,
  output logic            rr_q_o,
  output logic [CH_W-1:0] ptr_q_o,
  output logic [CH_W-1:0] ptr_eff_o
);
  logic take;
  logic load;

  assign take      = valid_o && ready_i;
  assign load      = !valid_o || ready_i;
  assign ptr_eff_o = (take && rr_q_o) ? chan_o - 1'b1 : ptr_q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      chan_o  <= '0;
      rr_q_o  <= 1'b0;
      ptr_q_o <= '1;
    end else begin
      ptr_q_o <= ptr_eff_o;
      if (load) begin
        valid_o <= cand_hit_i;
        rr_q_o  <= cand_rr_i;
        if (cand_hit_i) chan_o <= cand_chan_i;
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     rr_mode_i,
  input  logic                     grp_first_i,
  output logic                     gnt_valid_o,
  input  logic                     gnt_ready_i,
  output logic [CH_W-1:0]          gnt_chan_o
);
  arb_mode_e       mode;
  logic            fx_hit, rr_hit, cand_hit;
  logic [CH_W-1:0] fx_chan, rr_chan, cand_chan;
  logic [CH_W-1:0] rr_ptr, ptr_eff;
  logic            gnt_rr;

  assign mode = arb_mode_e'(rr_mode_i);

  dma_arb_fixed #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
    .req_i       (req_i),
    .prio_i      (prio_i),
    .grp_first_i (grp_first_i),
    .hit_o       (fx_hit),
    .chan_o      (fx_chan)
  );

  dma_arb_rr #(.NUM_CH(NUM_CH)) u_rr (
    .req_i   (req_i),
    .start_i (ptr_eff),
    .hit_o   (rr_hit),
    .chan_o  (rr_chan)
  );

  always_comb begin
    if (mode == ARB_RR) begin
      cand_hit  = rr_hit;
      cand_chan = rr_chan;
    end else begin
      cand_hit  = fx_hit;
      cand_chan = fx_chan;
    end
  end

  dma_arb_out #(.CH_W(CH_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_hit_i  (cand_hit),
    .cand_chan_i (cand_chan),
    .cand_rr_i   (mode == ARB_RR),
    .ready_i     (gnt_ready_i),
    .valid_o     (gnt_valid_o),
    .chan_o      (gnt_chan_o),
    .rr_q_o      (gnt_rr),
    .ptr_q_o     (rr_ptr),
    .ptr_eff_o   (ptr_eff)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic              gnt_valid_o,
  input logic              gnt_ready_i,
  input logic [CH_W-1:0]   gnt_chan_o,
  input logic [CH_W-1:0]   rr_ptr,
  input logic              gnt_rr
);
  logic [NUM_CH-1:0] req_q;
  logic              load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      load_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      load_q <= !gnt_valid_o || gnt_ready_i;
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_valid_o || gnt_ready_i) && (|req_i)) |=> gnt_valid_o);

  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gnt_valid_o || gnt_ready_i) && req_i == '0) |=> !gnt_valid_o);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && !gnt_ready_i) |=> (gnt_valid_o && $stable(gnt_chan_o)));

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid_o && gnt_ready_i && gnt_rr) |=> $stable(rr_ptr));

  a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && gnt_ready_i && gnt_rr) |=> rr_ptr == CH_W'($past(gnt_chan_o) - 1'b1));

  a_r10_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && gnt_valid_o) |-> req_q[gnt_chan_o]);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .gnt_valid_o (gnt_valid_o),
  .gnt_ready_i (gnt_ready_i),
  .gnt_chan_o  (gnt_chan_o),
  .rr_ptr      (rr_ptr),
  .gnt_rr      (gnt_rr)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
  localparam int NUM_CH = 32;
  localparam int PRIO_W = 4;
  localparam int CH_W   = $clog2(NUM_CH);

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic [NUM_CH-1:0]        req;
  logic [NUM_CH*PRIO_W-1:0] prio;
  logic                     rr_mode, grp_first, ready;
  logic                     gnt_valid;
  logic [CH_W-1:0]          gnt_chan;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dma_req_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .prio_i      (prio),
    .rr_mode_i   (rr_mode),
    .grp_first_i (grp_first),
    .gnt_valid_o (gnt_valid),
    .gnt_ready_i (ready),
    .gnt_chan_o  (gnt_chan)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_prio(input int ch, input int val);
    prio[ch*PRIO_W +: PRIO_W] = PRIO_W'(val);
  endtask

  task automatic expect_gnt(input string rid, input logic v_exp, input int ch_exp);
    vectors++;
    if (gnt_valid !== v_exp || (v_exp && gnt_chan !== CH_W'(ch_exp))) begin
      fails++;
      $display("FAIL %s: valid=%0b chan=%0d, expected valid=%0b chan=%0d",
               rid, gnt_valid, gnt_chan, v_exp, ch_exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '0; prio = '0; rr_mode = 1'b0; grp_first = 1'b0; ready = 1'b1;
    repeat (3) tick();
    expect_gnt("R1 reset", 1'b0, 0);
    rst_n = 1'b1;
    tick();
    expect_gnt("R3 no request", 1'b0, 0);
  endtask

  task automatic t_fixed();
    set_prio(5, 9); set_prio(12, 3); set_prio(3, 0);
    req = '0; req[5] = 1'b1; req[12] = 1'b1; req[3] = 1'b1;
    tick();
    expect_gnt("R5 R2 highest priority", 1'b1, 5);
    req[5] = 1'b0;
    tick();
    expect_gnt("R5 next highest", 1'b1, 12);
  endtask

  task automatic t_tie();
    set_prio(2, 7); set_prio(9, 7);
    req = '0; req[2] = 1'b1; req[9] = 1'b1;
    tick();
    expect_gnt("R6 tie to higher index", 1'b1, 9);
  endtask

  task automatic t_group();
    set_prio(20, 15); set_prio(1, 1);
    grp_first = 1'b0;
    req = '0; req[20] = 1'b1; req[1] = 1'b1;
    tick();
    expect_gnt("R7 lower group first", 1'b1, 1);
    grp_first = 1'b1;
    tick();
    expect_gnt("R7 upper group first", 1'b1, 20);
    grp_first = 1'b0;
    req = '0; req[17] = 1'b1;
    tick();
    expect_gnt("R7 fall back to other group", 1'b1, 17);
  endtask

  task automatic t_rr_walk();
    req = '0;
    tick();
    rr_mode = 1'b1;
    set_prio(0, 15);
    req = '1;
    tick();
    expect_gnt("R1 R8 pointer starts at top", 1'b1, 31);
    tick();
    expect_gnt("R8 descend", 1'b1, 30);
    tick();
    expect_gnt("R8 descend", 1'b1, 29);
    req = '0; req[31] = 1'b1; req[0] = 1'b1;
    tick();
    expect_gnt("R8 ignores priority", 1'b1, 0);
    tick();
    expect_gnt("R8 wrap to top", 1'b1, 31);
  endtask

  task automatic t_backpressure();
    ready = 1'b0;
    req = '0; req[4] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_gnt("R4 hold under back-pressure", 1'b1, 31);
    end
    ready = 1'b1;
    tick();
    expect_gnt("R9 R10 pointer advanced past 31", 1'b1, 4);
    req = '0;
    tick();
    expect_gnt("R3 drained", 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_gnt("R3 idle", 1'b0, 0);
    end
    req[10] = 1'b1; req[2] = 1'b1;
    tick();
    expect_gnt("R9 pointer held while idle", 1'b1, 2);
  endtask

  task automatic t_mode_mix();
    rr_mode = 1'b0;
    req = '0; req[7] = 1'b1;
    tick();
    expect_gnt("R5 fixed after round robin", 1'b1, 7);
    tick();
    expect_gnt("R5 repeated fixed grant", 1'b1, 7);
    req = '0;
    tick();
    expect_gnt("R3 idle", 1'b0, 0);
    rr_mode = 1'b1;
    req[10] = 1'b1; req[1] = 1'b1;
    tick();
    expect_gnt("R9 fixed grants leave pointer", 1'b1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_tie();
    t_group();
    t_rr_walk();
    t_backpressure();
    t_mode_mix();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule